// File: doc/BRIEF.md
# Sync-Aligned Burst Sample Trigger

This block is a slave timer that starts a short train of sample-start pulses for an analog-to-digital converter each time a master PWM timer begins a new period. The master is seen only as a one-clock sync pulse. That pulse may come from the master's zero point or from one of its compare matches. The sync pulse does three things at once. It zeroes the slave counter, it copies the programmed (shadow) spacing into the working spacing, and it arms triggering. The slave then issues a fixed number of evenly spaced one-clock trigger pulses. After the last pulse it disarms itself and waits for the next sync.

The master's frequency may drift between syncs, for example anywhere from about 80 to 90 kHz. Because of this, software rewrites the shadow spacing at any time, and the new value only matters from the next sync on. The burst therefore always lines up again with the master. A one-clock done pulse follows the final trigger of each burst. A sticky overrun flag records any sync that arrives while a burst is still running. The defaults give 20 triggers spaced 30 clocks apart.

Top module: `sync_burst_trig`

## Requirements
- R1: After a synchronous active-high reset, trig_out, done_out, busy_out and overrun_out are 0. The shadow spacing value is 29 and the burst length is 20, so a sync with no prior writes produces 20 triggers spaced 30 clocks apart.
- R2: A sync_in pulse sampled on clock edge S zeroes the counter and loads the shadow spacing value P. A zero P is taken as 1. The block raises busy_out after edge S, and trigger k of the burst is high in the cycle after edge S + k*(P+1).
- R3: Every trigger pulse is exactly one clock wide. This holds even at the smallest spacing, where triggers are two clocks apart.
- R4: A burst of length N gives exactly N triggers and then no more until the next sync. busy_out falls in the same cycle that the last trigger is high.
- R5: done_out is high for exactly one clock, in the cycle just after the last trigger of a burst.
- R6: Writing register 0 (the shadow spacing, the full data width) while a burst runs does not change that burst's spacing. The new value applies from the next sync.
- R7: A burst length of 0 disables bursts. A sync then gives no triggers and no done pulse, and busy_out stays low.
- R8: A sync that arrives while busy_out is high sets overrun_out and restarts the burst from zero using the current shadow values. If the sync lands on the same edge as a pending trigger, the sync wins: that trigger and its done pulse are dropped.
- R9: overrun_out stays set until a write to register 2 with data bit 0 equal to 1. A write to register 2 with bit 0 equal to 0, or a write to register 3, leaves it set. If a clear and a setting sync fall on the same edge, the flag stays set.
- R10: Register 1 holds the burst length (1 to 63) in data bits 5:0. The length is captured at sync, so writing it during a burst does not change the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | One-clock sync pulse from the master timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 spacing, 1 length, 2 control, 3 unused |
| wr_data | input | PER_W | Write data |
| trig_out | output | 1 | One-clock sample-start pulse |
| done_out | output | 1 | One-clock pulse after the final trigger of a burst |
| busy_out | output | 1 | Burst in progress |
| overrun_out | output | 1 | Sticky flag: a sync arrived during a burst |

## Verification
The sharpest collision is a new sync landing on the exact edge where the running burst's last compare match would fire its final trigger. The bench provokes this by counting cycles from the previous sync and driving sync_in so that it is sampled on that edge. A correct block shows no trigger and no done pulse from the old burst, sets the overrun flag, and produces a fresh burst timed from the new edge. A second collision is an overrun clear written on the same edge as a setting sync, which is judged by the flag staying high.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SPACING = 2'd0,
    REG_LENGTH  = 2'd1,
    REG_CTRL    = 2'd2,
    REG_SPARE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/sbt_regs.sv
module sbt_regs
  import sbt_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int LEN_W   = 6,
  parameter int RST_PER = 29,
  parameter int RST_LEN = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_W-1:0]  wr_data,
  output logic [PER_W-1:0]  shadow_per,
  output logic [LEN_W-1:0]  burst_len,
  output logic              ovr_clr
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(wr_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_per <= PER_W'(RST_PER);
      burst_len  <= LEN_W'(RST_LEN);
    end else if (wr_en) begin
      case (sel)
        REG_SPACING: shadow_per <= wr_data;
        REG_LENGTH:  burst_len  <= wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign ovr_clr = wr_en && (sel == REG_CTRL) && wr_data[0];
endmodule

// File: rtl/sbt_timer.sv
module sbt_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             run,
  input  logic [PER_W-1:0] shadow_per,
  output logic             hit
);
  localparam logic [PER_W-1:0] ONE = PER_W'(1);

  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] act_per;
  logic [PER_W-1:0] load_per;

  // a spacing of zero would make back-to-back triggers; clamp to one
  assign load_per = (shadow_per == '0) ? ONE : shadow_per;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      act_per <= ONE;
    end else if (sync) begin
      cnt     <= '0;
      act_per <= load_per;
    end else if (run) begin
      cnt <= (cnt == act_per) ? '0 : cnt + ONE;
    end else begin
      cnt <= '0;
    end
  end

  assign hit = run && !sync && (cnt == act_per);
endmodule

// File: rtl/sbt_seq.sv
module sbt_seq #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync,
  input  logic             hit,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             ovr_clr,
  output logic             run,
  output logic             trig,
  output logic             done,
  output logic             overrun
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] smp_q;
  logic             last_q;
  logic             is_last;

  assign is_last = (smp_q == len_q - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      len_q   <= '0;
      smp_q   <= '0;
      trig    <= 1'b0;
      last_q  <= 1'b0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      trig   <= hit;
      last_q <= hit && is_last;
      done   <= trig && last_q;

      if (sync) begin
        run   <= (burst_len != '0);
        len_q <= burst_len;
        smp_q <= '0;
      end else if (hit) begin
        smp_q <= smp_q + ONE;
        if (is_last) run <= 1'b0;
      end

      // setting has priority over a clear on the same edge
      if (sync && run)  overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_burst_trig.sv
module sync_burst_trig
  import sbt_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int LEN_W   = 6,
  parameter int RST_PER = 29,
  parameter int RST_LEN = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [PER_W-1:0] wr_data,
  output logic             trig_out,
  output logic             done_out,
  output logic             busy_out,
  output logic             overrun_out
);
  logic [PER_W-1:0] shadow_per;
  logic [LEN_W-1:0] burst_len;
  logic             ovr_clr;
  logic             hit;
  logic             run;

  sbt_regs #(
    .PER_W(PER_W), .LEN_W(LEN_W), .RST_PER(RST_PER), .RST_LEN(RST_LEN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .shadow_per(shadow_per), .burst_len(burst_len), .ovr_clr(ovr_clr)
  );

  sbt_timer #(.PER_W(PER_W)) u_timer (
    .clk(clk), .rst(rst), .sync(sync_in), .run(run),
    .shadow_per(shadow_per), .hit(hit)
  );

  sbt_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .sync(sync_in), .hit(hit), .burst_len(burst_len),
    .ovr_clr(ovr_clr), .run(run), .trig(trig_out), .done(done_out),
    .overrun(overrun_out)
  );

  assign busy_out = run;
endmodule

// File: rtl/sync_burst_trig_chk.sv
module sync_burst_trig_chk #(
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_in,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [PER_W-1:0] wr_data,
  input logic             trig_out,
  input logic             done_out,
  input logic             busy_out,
  input logic             overrun_out
);
  logic clr_req;
  assign clr_req = wr_en && (wr_addr == 2'd2) && wr_data[0];

  a_r3_trig_single: assert property (@(posedge clk) disable iff (rst)
    trig_out |=> !trig_out);

  a_r4_trig_needs_busy: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> $past(busy_out));

  a_r5_done_after_trig: assert property (@(posedge clk) disable iff (rst)
    done_out |-> $past(trig_out));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done_out |=> !done_out);

  a_r8_sync_sets_overrun: assert property (@(posedge clk) disable iff (rst)
    (sync_in && busy_out) |=> overrun_out);

  a_r9_overrun_holds: assert property (@(posedge clk) disable iff (rst)
    (overrun_out && !clr_req) |=> overrun_out);

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun_out) |-> $past(sync_in && busy_out));
endmodule

bind sync_burst_trig sync_burst_trig_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .sync_in(sync_in), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .trig_out(trig_out), .done_out(done_out),
  .busy_out(busy_out), .overrun_out(overrun_out)
);

// File: tb/sync_burst_trig_tb.sv
`timescale 1ns/1ps
module sync_burst_trig_tb;
  localparam int PER_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sync_in = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [PER_W-1:0] wr_data = '0;
  logic             trig_out, done_out, busy_out, overrun_out;

  sync_burst_trig #(.PER_W(PER_W)) u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_out(trig_out), .done_out(done_out),
    .busy_out(busy_out), .overrun_out(overrun_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  exp_t trig_q[$];
  exp_t done_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   m_per = 29;
  int   m_len = 20;
  int   b_start = -100;
  int   b_end = -100;
  bit   m_ovr = 1'b0;

  task automatic check(input bit ok, input string tag, input int act,
                       input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = PER_W'(d);
    if (a == 2'd0) m_per = d;
    if (a == 2'd1) m_len = d & 63;
    if (a == 2'd2 && (d & 1) != 0) m_ovr = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: called at a negedge; sync is sampled at the next edge.
  task automatic fire_sync(input string tag);
    int s = cyc + 1;
    int sp = ((m_per == 0) ? 1 : m_per) + 1;
    if (s >= b_start + 1 && s <= b_end) m_ovr = 1'b1;
    while (trig_q.size() != 0 && trig_q[$].at >= s) void'(trig_q.pop_back());
    while (done_q.size() != 0 && done_q[$].at >= s + 1) void'(done_q.pop_back());
    if (m_len != 0) begin
      b_start = s;
      b_end = s + m_len * sp;
      for (int k = 1; k <= m_len; k++) trig_q.push_back('{s + k * sp, tag});
      done_q.push_back('{b_end + 1, tag});
    end else begin
      b_start = -100;
      b_end = -100;
    end
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    check(busy_out == (m_len != 0), (m_len != 0) ? "R2" : "R7", int'(busy_out),
          int'(m_len != 0), "busy after sync");
    check(overrun_out == m_ovr, "R8", int'(overrun_out), int'(m_ovr), "overrun after sync");
  endtask

  task automatic wait_idle(input string tag);
    while (trig_q.size() != 0 || done_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(busy_out == 1'b0, tag, int'(busy_out), 0, "busy after burst");
  endtask

  // Monitor: pops expected items and compares against the ports.
  always @(negedge clk) begin
    if (!rst) begin
      if (trig_out) begin
        if (trig_q.size() == 0) check(1'b0, "R4", cyc, -1, "unexpected trigger");
        else begin
          check(trig_q[0].at == cyc, trig_q[0].tag, cyc, trig_q[0].at, "trigger cycle");
          void'(trig_q.pop_front());
        end
      end else if (trig_q.size() != 0 && trig_q[0].at <= cyc) begin
        check(1'b0, trig_q[0].tag, cyc, trig_q[0].at, "missing trigger");
        void'(trig_q.pop_front());
      end
      if (done_out) begin
        if (done_q.size() == 0) check(1'b0, "R5", cyc, -1, "unexpected done");
        else begin
          check(done_q[0].at == cyc, "R5", cyc, done_q[0].at, "done cycle");
          void'(done_q.pop_front());
        end
      end else if (done_q.size() != 0 && done_q[0].at <= cyc) begin
        check(1'b0, "R5", cyc, done_q[0].at, "missing done");
        void'(done_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R4: still running at cycle %0d, expected end before 100000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int tgt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(trig_out == 1'b0, "R1", int'(trig_out), 0, "trig after reset");
    check(done_out == 1'b0, "R1", int'(done_out), 0, "done after reset");
    check(busy_out == 1'b0, "R1", int'(busy_out), 0, "busy after reset");
    check(overrun_out == 1'b0, "R1", int'(overrun_out), 0, "overrun after reset");

    // R1: default burst, 20 triggers at 30-cycle spacing
    fire_sync("R1");
    wait_idle("R4");

    // R2/R6/R10: new values, mid-burst rewrites ignored until next sync
    wr(2'd0, 4);
    wr(2'd1, 3);
    fire_sync("R2");
    repeat (3) @(negedge clk);
    wr(2'd0, 9);
    wr(2'd1, 1);
    wait_idle("R10");
    fire_sync("R6");
    wait_idle("R6");

    // R3: smallest spacing (zero clamps to one)
    wr(2'd0, 0);
    wr(2'd1, 2);
    fire_sync("R3");
    wait_idle("R3");

    // R7: length zero disables bursts
    wr(2'd1, 0);
    fire_sync("R7");
    repeat (40) @(negedge clk);
    check(busy_out == 1'b0, "R7", int'(busy_out), 0, "busy with zero length");

    // R8: sync during a burst restarts it and sets overrun
    wr(2'd0, 6);
    wr(2'd1, 5);
    fire_sync("R8");
    repeat (10) @(negedge clk);
    check(overrun_out == 1'b0, "R8", int'(overrun_out), 0, "overrun before resync");
    fire_sync("R8");
    wait_idle("R8");
    check(overrun_out == 1'b1, "R9", int'(overrun_out), 1, "overrun sticky after burst");

    // R9: only a control write with bit 0 set clears the flag
    wr(2'd2, 0);
    check(overrun_out == 1'b1, "R9", int'(overrun_out), 1, "clear bit zero");
    wr(2'd3, 1);
    check(overrun_out == 1'b1, "R9", int'(overrun_out), 1, "spare register write");
    wr(2'd2, 1);
    check(overrun_out == 1'b0, "R9", int'(overrun_out), 0, "overrun cleared");

    // R8: sync on the same edge as the final compare match
    wr(2'd0, 3);
    wr(2'd1, 2);
    fire_sync("R8");
    tgt = b_end;
    while (cyc != tgt - 1) @(negedge clk);
    fire_sync("R8");
    wait_idle("R8");
    check(overrun_out == 1'b1, "R8", int'(overrun_out), 1, "overrun after collision");

    // R9: clear and setting sync on the same edge, set wins
    wr(2'd2, 1);
    wr(2'd0, 5);
    wr(2'd1, 4);
    fire_sync("R9");
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = PER_W'(1);
    fire_sync("R9");
    wr_en = 1'b0;
    check(overrun_out == 1'b1, "R9", int'(overrun_out), 1, "set beats clear");
    wait_idle("R4");
    wr(2'd2, 1);
    check(overrun_out == 1'b0, "R9", int'(overrun_out), 0, "final clear");

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule